// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a DDR SDRAM from the moment reset is released until the memory is ready for normal traffic. It holds the clock enable low through a long power-up settling period. It then raises the clock enable and walks the fixed bring-up order. Each step is a command followed by the minimum spacing that the memory needs before the next command. It ends by asserting `init_done`. After that the surrounding controller may take over the bus.

All waits are given in nanoseconds against a clock period in picoseconds. Each wait is converted at elaboration to a whole number of cycles by rounding up. The lock wait after the DLL reset is given directly in cycles. The mode-register fields (burst length, burst order, read latency) and the output drive option come from input ports. A build option can take them from parameters instead, and in that case the codes are range-checked at elaboration.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and for exactly PWRUP_CYC = ceil(PWRUP_NS*1000/CLK_PS) rising edges after reset is released, `cke` is 0 and the bus carries NOP (`cs_n,ras_n,cas_n,we_n` = 0,1,1,1).
- R2: In the cycle after the power-up wait, `cke` rises with NOP on the bus. `cke` then stays high until the next reset.
- R3: After `cke` rises, exactly seven non-NOP commands appear, in this order. First a precharge-all (encoding 0,0,1,0 with `addr[10]`=1 and `ba`=0). Then a load to the extended register (encoding 0,0,0,0, `ba`=01), then a load to the base register (`ba`=00) with the DLL reset bit set. Then a precharge-all, then two auto refreshes (encoding 0,0,0,1, `ba`=0, `addr`=0). Last comes a load to the base register with the DLL reset bit clear.
- R4: The extended-register word has bit 0 = 0 (DLL on), bit 1 = the reduced-drive option, and all other bits 0.
- R5: The base-register word carries the burst-length code in bits 2:0, the burst order in bit 3 (1 = interleaved) and the read-latency code in bits 6:4 (010 = 2, 110 = 2.5). Bit 8 is 1 on the first load and 0 on the final load. Bit 7 and bits 9 and up are 0.
- R6: The first precharge comes one cycle after `cke` rises. Each later command follows the previous one by exactly its spacing: TRP_CYC after a precharge, TMRD_CYC after a register load, TRFC_CYC after a refresh. Each spacing is the rounded-up ns/period value, with a minimum of 1.
- R7: `init_done` first rises in cycle max(t_dll + LOCK_CYC, t_last + TMRD_CYC). Here t_dll is the cycle of the DLL-reset load and t_last is the cycle of the final load. `init_done` then stays high, with NOP on the bus, until reset.
- R8: Asserting reset at any point, including mid-sequence and after `init_done`, immediately drops `cke` and `init_done`. The full sequence then restarts from the power-up wait.
- R9: With CFG_FROM_PORTS = 0, the register words are built from parameters and the four configuration inputs have no effect. The burst-length code must be 001, 010 or 011 and the latency code must be 010 or 110, otherwise elaboration fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bl | input | 3 | Burst-length code for the base register |
| cfg_interleave | input | 1 | Burst order: 1 interleaved, 0 sequential |
| cfg_cl | input | 3 | Read-latency code for the base register |
| cfg_drive_low | input | 1 | Select reduced output drive |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank / register select |
| addr | output | ADDR_W | Address / register word |
| init_done | output | 1 | Sequence complete and DLL lock time met |

## Verification
A state register that skips or repeats a step shows on the bus within one command slot. It appears as a missing, duplicated or reordered command, so the recorded command list is compared entry by entry against the expected order. A spacing counter loaded with the wrong value shifts every later command time, and the first wrong slot reveals it at the next command boundary. A lock counter that starts late or never starts moves the rise of `init_done` away from its computed cycle. This is checked both with the lock wait dominant and with the final register load dominant.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [3:0] {
      ST_PWRUP,
      ST_CKE_UP,
      ST_PRE_A,
      ST_EMR,
      ST_MR_DLL,
      ST_PRE_B,
      ST_REF_A,
      ST_REF_B,
      ST_MR_RUN,
      ST_FINAL
   } seq_state_t;

   // {cs_n, ras_n, cas_n, we_n}
   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t CMD_NOP = 4'b0111;
   localparam cmd_pins_t CMD_PRE = 4'b0010;
   localparam cmd_pins_t CMD_REF = 4'b0001;
   localparam cmd_pins_t CMD_LMR = 4'b0000;

   localparam logic [1:0] SEL_BASE = 2'b00;
   localparam logic [1:0] SEL_EXT  = 2'b01;

   // rounded-up cycle count, never below one
   function automatic int ns_to_cyc(input int ns, input int period_ps);
      int c;
      c = (ns * 1000 + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= RST_VAL;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_mode_enc.sv
module ddr_init_mode_enc #(
   parameter int unsigned ADDR_W         = 13,
   parameter bit          CFG_FROM_PORTS = 1'b1,
   parameter logic [2:0]  BL_CODE        = 3'b010,
   parameter logic        BT_CODE        = 1'b0,
   parameter logic [2:0]  CL_CODE        = 3'b010,
   parameter logic        DRV_REDUCED    = 1'b0
) (
   input  logic [2:0]        bl_i,
   input  logic              bt_i,
   input  logic [2:0]        cl_i,
   input  logic              drv_i,
   input  logic              dll_rst_i,
   output logic [ADDR_W-1:0] mr_word,
   output logic [ADDR_W-1:0] emr_word
);

   logic [2:0] bl_sel;
   logic       bt_sel;
   logic [2:0] cl_sel;
   logic       drv_sel;

   generate
      if (CFG_FROM_PORTS) begin : g_port_cfg
         assign bl_sel  = bl_i;
         assign bt_sel  = bt_i;
         assign cl_sel  = cl_i;
         assign drv_sel = drv_i;
      end else begin : g_param_cfg
         if (!(BL_CODE == 3'b001 || BL_CODE == 3'b010 || BL_CODE == 3'b011)) begin : g_bad_bl
            $error("burst length code not one of 2, 4, 8");
         end
         if (!(CL_CODE == 3'b010 || CL_CODE == 3'b110)) begin : g_bad_cl
            $error("read latency code not one of 2, 2.5");
         end
         assign bl_sel  = BL_CODE;
         assign bt_sel  = BT_CODE;
         assign cl_sel  = CL_CODE;
         assign drv_sel = DRV_REDUCED;
      end
   endgenerate

   always_comb begin
      mr_word      = '0;
      mr_word[2:0] = bl_sel;
      mr_word[3]   = bt_sel;
      mr_word[6:4] = cl_sel;
      mr_word[8]   = dll_rst_i;
   end

   always_comb begin
      emr_word    = '0;
      emr_word[0] = 1'b0;      // DLL on
      emr_word[1] = drv_sel;
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int          CLK_PS         = 20000,
   parameter int          PWRUP_NS       = 200000,
   parameter int          TRP_NS         = 20,
   parameter int          TMRD_NS        = 16,
   parameter int          TRFC_NS        = 75,
   parameter int          LOCK_CYC       = 200,
   parameter int unsigned ADDR_W         = 13,
   parameter bit          CFG_FROM_PORTS = 1'b1,
   parameter logic [2:0]  BL_CODE        = 3'b010,
   parameter logic        BT_CODE        = 1'b0,
   parameter logic [2:0]  CL_CODE        = 3'b010,
   parameter logic        DRV_REDUCED    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_bl,
   input  logic              cfg_interleave,
   input  logic [2:0]        cfg_cl,
   input  logic              cfg_drive_low,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int PWRUP_CYC = ns_to_cyc(PWRUP_NS, CLK_PS);
   localparam int TRP_CYC   = ns_to_cyc(TRP_NS, CLK_PS);
   localparam int TMRD_CYC  = ns_to_cyc(TMRD_NS, CLK_PS);
   localparam int TRFC_CYC  = ns_to_cyc(TRFC_NS, CLK_PS);
   localparam int MAX_A     = (PWRUP_CYC > TRFC_CYC) ? PWRUP_CYC : TRFC_CYC;
   localparam int MAX_B     = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
   localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned TW = $clog2(MAX_CYC + 1);
   localparam int unsigned LW = $clog2(LOCK_CYC + 1);
   localparam logic [TW-1:0] PWRUP_LOAD = TW'(PWRUP_CYC - 1);
   localparam logic [LW-1:0] LOCK_LOAD  = LW'(LOCK_CYC - 1);

   generate
      if (ADDR_W < 11) begin : g_bad_aw
         $error("address bus must reach bit 10");
      end
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("lock wait must be at least one cycle");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("clock period must be positive");
      end
   endgenerate

   seq_state_t state_q, state_nxt;
   logic       fresh_q;
   logic       advance;
   logic       step_zero;
   logic [TW-1:0] step_load;
   logic       lock_armed_q;
   logic       lock_zero;
   logic       lock_start;
   logic       dll_rst_bit;
   logic [ADDR_W-1:0] mr_word, emr_word;
   cmd_pins_t  cmd;

   function automatic int spacing_of(input seq_state_t s);
      case (s)
         ST_PRE_A, ST_PRE_B:            return TRP_CYC;
         ST_EMR, ST_MR_DLL, ST_MR_RUN:  return TMRD_CYC;
         ST_REF_A, ST_REF_B:            return TRFC_CYC;
         default:                       return 1;
      endcase
   endfunction

   always_comb begin
      case (state_q)
         ST_PWRUP:  state_nxt = ST_CKE_UP;
         ST_CKE_UP: state_nxt = ST_PRE_A;
         ST_PRE_A:  state_nxt = ST_EMR;
         ST_EMR:    state_nxt = ST_MR_DLL;
         ST_MR_DLL: state_nxt = ST_PRE_B;
         ST_PRE_B:  state_nxt = ST_REF_A;
         ST_REF_A:  state_nxt = ST_REF_B;
         ST_REF_B:  state_nxt = ST_MR_RUN;
         default:   state_nxt = ST_FINAL;
      endcase
   end

   assign advance   = step_zero && (state_q != ST_FINAL);
   assign step_load = TW'(spacing_of(state_nxt) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PWRUP;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= advance;
         if (advance)
            state_q <= state_nxt;
      end
   end

   ddr_init_timer #(
      .W       (TW),
      .RST_VAL (PWRUP_LOAD)
   ) u_step_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (advance),
      .load_val (step_load),
      .zero     (step_zero)
   );

   assign lock_start = (state_q == ST_MR_DLL) && fresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_armed_q <= 1'b0;
      else if (lock_start)
         lock_armed_q <= 1'b1;
   end

   ddr_init_timer #(
      .W       (LW),
      .RST_VAL ('0)
   ) u_lock_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (lock_start),
      .load_val (LOCK_LOAD),
      .zero     (lock_zero)
   );

   assign dll_rst_bit = (state_q == ST_MR_DLL);

   ddr_init_mode_enc #(
      .ADDR_W         (ADDR_W),
      .CFG_FROM_PORTS (CFG_FROM_PORTS),
      .BL_CODE        (BL_CODE),
      .BT_CODE        (BT_CODE),
      .CL_CODE        (CL_CODE),
      .DRV_REDUCED    (DRV_REDUCED)
   ) u_mode (
      .bl_i      (cfg_bl),
      .bt_i      (cfg_interleave),
      .cl_i      (cfg_cl),
      .drv_i     (cfg_drive_low),
      .dll_rst_i (dll_rst_bit),
      .mr_word   (mr_word),
      .emr_word  (emr_word)
   );

   always_comb begin
      cmd  = CMD_NOP;
      ba   = 2'b00;
      addr = '0;
      if (fresh_q) begin
         case (state_q)
            ST_PRE_A, ST_PRE_B: begin
               cmd      = CMD_PRE;
               addr[10] = 1'b1;
            end
            ST_EMR: begin
               cmd  = CMD_LMR;
               ba   = SEL_EXT;
               addr = emr_word;
            end
            ST_MR_DLL, ST_MR_RUN: begin
               cmd  = CMD_LMR;
               ba   = SEL_BASE;
               addr = mr_word;
            end
            ST_REF_A, ST_REF_B: cmd = CMD_REF;
            default:            cmd = CMD_NOP;
         endcase
      end
   end

   assign cke       = (state_q != ST_PWRUP);
   assign cs_n      = cmd.cs_n;
   assign ras_n     = cmd.ras_n;
   assign cas_n     = cmd.cas_n;
   assign we_n      = cmd.we_n;
   assign init_done = (state_q == ST_FINAL) && lock_armed_q && lock_zero;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
   parameter int unsigned AW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cke,
   input logic          cs_n,
   input logic          ras_n,
   input logic          cas_n,
   input logic          we_n,
   input logic [1:0]    ba,
   input logic [AW-1:0] addr,
   input logic          init_done
);

   logic [3:0] pins;
   logic       is_nop, is_lmr, is_pre;

   assign pins   = {cs_n, ras_n, cas_n, we_n};
   assign is_nop = (pins == 4'b0111);
   assign is_lmr = (pins == 4'b0000);
   assign is_pre = (pins == 4'b0010);

   // R8
   always @(posedge clk) begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!cke && !init_done && is_nop);
      end
   end

   // R1
   pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (is_nop && !init_done));

   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (is_nop && cke));

   // R3
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (addr[10] && cke));

   // R4
   emr_dll_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lmr && ba == 2'b01) |-> (!addr[0] && addr[AW-1:2] == '0));

   // R5
   mr_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lmr && ba == 2'b00) |-> (!addr[7] && addr[AW-1:9] == '0));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.AW(ADDR_W)) u_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .init_done (init_done)
);

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;

   function automatic int up_cyc(input int ns, input int ps);
      int c;
      c = (ns * 1000 + ps - 1) / ps;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int CLK_PS  = 20000;
   localparam int PW_NS   = 2000;
   localparam int RP_NS   = 45;
   localparam int MRD_NS  = 30;
   localparam int RFC_NS  = 130;
   localparam int LOCK_A  = 200;
   localparam int LOCK_B  = 10;
   localparam int P_CYC   = up_cyc(PW_NS, CLK_PS);
   localparam int RP_CYC  = up_cyc(RP_NS, CLK_PS);
   localparam int MRD_CYC = up_cyc(MRD_NS, CLK_PS);
   localparam int RFC_CYC = up_cyc(RFC_NS, CLK_PS);

   typedef struct packed {
      logic [3:0]  enc;
      logic [1:0]  bsel;
      logic [12:0] adr_a;
      logic [12:0] adr_b;
      int          gap;
   } step_t;

   // expected command list; dut uses port config, dut_short parameter config
   localparam step_t STEPS [7] = '{
      '{4'b0010, 2'b00, 13'h400, 13'h400, RP_CYC},
      '{4'b0000, 2'b01, 13'h002, 13'h000, MRD_CYC},
      '{4'b0000, 2'b00, 13'h16A, 13'h123, MRD_CYC},
      '{4'b0010, 2'b00, 13'h400, 13'h400, RP_CYC},
      '{4'b0001, 2'b00, 13'h000, 13'h000, RFC_CYC},
      '{4'b0001, 2'b00, 13'h000, 13'h000, RFC_CYC},
      '{4'b0000, 2'b00, 13'h06A, 13'h023, MRD_CYC}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cfg_bl = 3'b010;
   logic       cfg_il = 1'b1;
   logic [2:0] cfg_cl = 3'b110;
   logic       cfg_drv = 1'b1;

   logic        cke_w [2];
   logic [3:0]  enc_w [2];
   logic [1:0]  ba_w  [2];
   logic [12:0] adr_w [2];
   logic        done_w[2];
   logic cs0, ras0, cas0, we0, cs1, ras1, cas1, we1;

   always #10ns clk = ~clk;

   ddr_init_seq #(
      .CLK_PS(CLK_PS), .PWRUP_NS(PW_NS), .TRP_NS(RP_NS), .TMRD_NS(MRD_NS),
      .TRFC_NS(RFC_NS), .LOCK_CYC(LOCK_A), .ADDR_W(13), .CFG_FROM_PORTS(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_interleave(cfg_il),
      .cfg_cl(cfg_cl), .cfg_drive_low(cfg_drv), .cke(cke_w[0]), .cs_n(cs0),
      .ras_n(ras0), .cas_n(cas0), .we_n(we0), .ba(ba_w[0]), .addr(adr_w[0]),
      .init_done(done_w[0])
   );

   ddr_init_seq #(
      .CLK_PS(CLK_PS), .PWRUP_NS(PW_NS), .TRP_NS(RP_NS), .TMRD_NS(MRD_NS),
      .TRFC_NS(RFC_NS), .LOCK_CYC(LOCK_B), .ADDR_W(13), .CFG_FROM_PORTS(1'b0),
      .BL_CODE(3'b011), .BT_CODE(1'b0), .CL_CODE(3'b010), .DRV_REDUCED(1'b0)
   ) dut_short (
      .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_interleave(cfg_il),
      .cfg_cl(cfg_cl), .cfg_drive_low(cfg_drv), .cke(cke_w[1]), .cs_n(cs1),
      .ras_n(ras1), .cas_n(cas1), .we_n(we1), .ba(ba_w[1]), .addr(adr_w[1]),
      .init_done(done_w[1])
   );

   assign enc_w[0] = {cs0, ras0, cas0, we0};
   assign enc_w[1] = {cs1, ras1, cas1, we1};

   int checks = 0;
   int errors = 0;
   int wd = 0;
   int cyc = 0;
   int n_cmd   [2];
   int rise_at [2];
   int done_at [2];
   bit quiet_bad [2];
   bit after_bad [2];
   int          rec_t [2][8];
   logic [3:0]  rec_e [2][8];
   logic [1:0]  rec_b [2][8];
   logic [12:0] rec_a [2][8];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd >= 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 100000", wd);
         finish_run();
      end
   end

   // monitor: sample away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         cyc = 0;
         for (int d = 0; d < 2; d++) begin
            n_cmd[d] = 0; rise_at[d] = -1; done_at[d] = -1;
            quiet_bad[d] = 1'b0; after_bad[d] = 1'b0;
         end
      end else begin
         cyc++;
         for (int d = 0; d < 2; d++) begin
            if (cke_w[d] && rise_at[d] < 0) rise_at[d] = cyc;
            if (!cke_w[d] && enc_w[d] != 4'b0111) quiet_bad[d] = 1'b1;
            if (done_at[d] >= 0 && (!done_w[d] || enc_w[d] != 4'b0111 || !cke_w[d]))
               after_bad[d] = 1'b1;
            if (done_w[d] && done_at[d] < 0) done_at[d] = cyc;
            if (enc_w[d] != 4'b0111) begin
               if (n_cmd[d] < 8) begin
                  rec_t[d][n_cmd[d]] = cyc;
                  rec_e[d][n_cmd[d]] = enc_w[d];
                  rec_b[d][n_cmd[d]] = ba_w[d];
                  rec_a[d][n_cmd[d]] = adr_w[d];
               end
               n_cmd[d]++;
            end
         end
      end
   end

   task automatic release_reset();
      @(negedge clk);
      #2ns rst_n = 1'b1;
   endtask

   task automatic reset_now(input string tag);
      @(negedge clk);
      #2ns rst_n = 1'b0;
      #1ns;
      for (int d = 0; d < 2; d++) begin
         // R8: async drop of enable and done
         check(cke_w[d] == 1'b0, "R8", {tag, " cke on reset"}, cke_w[d], 0);
         check(done_w[d] == 1'b0, "R8", {tag, " done on reset"}, done_w[d], 0);
      end
      repeat (3) @(posedge clk);
   endtask

   task automatic run_and_check(input string tag);
      int t_exp, t_dll, t_last, d_exp, guard, lk;
      guard = 0;
      while ((done_at[0] < 0 || done_at[1] < 0) && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      #1ns;
      for (int d = 0; d < 2; d++) begin
         lk = (d == 0) ? LOCK_A : LOCK_B;
         // R1, R2: enable rises after exactly the power-up count
         check(rise_at[d] == P_CYC, "R1", {tag, " cke rise cycle"}, rise_at[d], P_CYC);
         check(!quiet_bad[d], "R1", {tag, " command while cke low"}, quiet_bad[d], 0);
         check(n_cmd[d] == 7, "R3", {tag, " command count"}, n_cmd[d], 7);
         t_exp = P_CYC + 1;      // R2/R6: first precharge one cycle after rise
         t_dll = 0; t_last = 0;
         for (int i = 0; i < 7; i++) begin
            logic [12:0] ea;
            string ar;
            ea = (d == 0) ? STEPS[i].adr_a : STEPS[i].adr_b;
            ar = (i == 1) ? "R4" : ((i == 2 || i == 6) ? ((d == 1) ? "R9" : "R5") : "R3");
            check(rec_e[d][i] == STEPS[i].enc, "R3", $sformatf("%s cmd %0d code", tag, i),
                  rec_e[d][i], STEPS[i].enc);
            check(rec_b[d][i] == STEPS[i].bsel, "R3", $sformatf("%s cmd %0d bank", tag, i),
                  rec_b[d][i], STEPS[i].bsel);
            check(rec_a[d][i] == ea, ar, $sformatf("%s cmd %0d word", tag, i),
                  rec_a[d][i], ea);
            check(rec_t[d][i] == t_exp, "R6", $sformatf("%s cmd %0d cycle", tag, i),
                  rec_t[d][i], t_exp);
            if (i == 2) t_dll = t_exp;
            if (i == 6) t_last = t_exp;
            t_exp += STEPS[i].gap;
         end
         d_exp = (t_dll + lk > t_last + MRD_CYC) ? (t_dll + lk) : (t_last + MRD_CYC);
         check(done_at[d] == d_exp, "R7", {tag, " done rise cycle"}, done_at[d], d_exp);
      end
      repeat (20) @(negedge clk);
      #1ns;
      for (int d = 0; d < 2; d++)
         check(!after_bad[d], "R7", {tag, " done held with NOP"}, after_bad[d], 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1ns;
      for (int d = 0; d < 2; d++) begin
         check(cke_w[d] == 1'b0, "R1", "reset cke", cke_w[d], 0);
         check(enc_w[d] == 4'b0111, "R1", "reset NOP", enc_w[d], 4'b0111);
         check(done_w[d] == 1'b0, "R8", "reset done", done_w[d], 0);
      end
      // mid-sequence reset, then a full run
      release_reset();
      while (cyc < P_CYC + 15) @(negedge clk);
      reset_now("mid");
      release_reset();
      run_and_check("restart");
      // reset after completion, then a second full run
      reset_now("after done");
      release_reset();
      run_and_check("second");
      finish_run();
   end

endmodule